// File: doc/BRIEF.md
# Home-side MESI controller for one inclusive L2 line

This block tracks the coherence state of a single line held in an inclusive second-level cache. Up to N private first-level caches share that line. The block takes in four kinds of traffic:

- requests from the first-level caches: shared read, instruction read, exclusive read, upgrade and dirty writeback;
- data returned by memory;
- writeback data from a first-level cache that owns the line;
- unblock messages from a requestor whose reply has arrived.

It keeps a sharer bit vector, the identity of an exclusive owner and a dirty flag. Its state is either stable (absent, shared, modified in L2, owned by a first-level cache) or transient.

In reply it emits several kinds of message:

- memory fetches;
- data or ack replies with a signed invalidation-ack count, so that a writer knows how many invalidation acks to collect;
- invalidations to sharers;
- requests forwarded to the owning cache;
- writeback acks.

Read misses that arrive while a fetch is outstanding are merged into one multicast reply. A request that cannot be served in the current state is refused by holding `req_ready` low. The requester presents it again later.

Each input is consumed on a clock edge. Every output is a registered one-cycle pulse that appears on the clock edge after the input was taken.

Top module: `l2_line_home`

## Requirements
- R1: After synchronous reset, the line is absent and no output pulse is asserted. `req_ready` is high for any request kind, where the kinds are encoded 0 shared read, 1 instruction read, 2 exclusive read, 3 upgrade and 4 writeback.
- R2: On an absent line, kind 0 moves to a single-reader fetch, kind 1 to a multi-reader fetch, and kind 2 or 3 to a write fetch. Each records the requestor and pulses `mem_rd` one cycle later.
- R3: Memory data in the single-reader fetch gives a reply of type 1 (exclusive data, types being 0 data, 1 exclusive data, 2 ack, 3 writeback ack) to that reader with count 0. In the write fetch it gives type 0 to the writer. Both then block until an exclusive unblock.
- R4: During a read fetch, further kind 0 or 1 requests are accepted and added to the reader set. Memory data then multicasts type 0, count 0, dirty 0 to the whole reader set, and the line becomes shared. Kinds 2 and 3 during any fetch, and reads during a write fetch, are refused.
- R5: A shared or instruction read on a shared line replies type 0 with count 0 to the requestor and adds it as a sharer.
- R6: An exclusive read on a shared line replies type 0 with count equal to minus the sharer count, plus one if the requestor is a sharer. It invalidates the sharers other than the requestor (only when that set is non-empty) and then blocks.
- R7: An upgrade from a current sharer replies type 2 with count 1 minus the sharer count and invalidates the other sharers. An upgrade from a non-sharer is handled as an exclusive read.
- R8: With the line modified in L2, a shared read gets type 1 with the stored dirty flag and blocks. An instruction read gets type 0, becomes a sharer and leaves the line shared.
- R9: With the line owned by a first-level cache, a read is forwarded to the owner with `fwd_excl` low. The line becomes shared only after both the requestor's plain unblock and the owner's writeback data have arrived, in either order. An exclusive read is forwarded with `fwd_excl` high and blocks.
- R10: An exclusive unblock in a modify-blocking state makes its sender the sole sharer and the owner, so that the next read is forwarded to it.
- R11: A writeback from the owner stores the line as dirty, clears the sharers, returns type 3 to the owner, and leaves the line modified in L2. A writeback from a non-sharer produces no output and changes nothing.
- R12: In every blocking state, requests of kinds 0 to 3 are refused with no output.
- R13: An unblock, memory data or writeback data present in a cycle takes priority, and `req_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | a request is presented |
| req_kind | input | 3 | request kind (0 shared read, 1 instruction read, 2 exclusive read, 3 upgrade, 4 writeback) |
| req_src | input | IDW | requesting cache index |
| req_ready | output | 1 | request accepted this cycle; low means retry |
| mem_valid | input | 1 | memory data arrives |
| wbd_valid | input | 1 | writeback data from the owning cache arrives |
| wbd_dirty | input | 1 | that writeback data is dirty |
| unb_valid | input | 1 | unblock message arrives |
| unb_excl | input | 1 | unblock is exclusive |
| unb_src | input | IDW | sender of the unblock |
| mem_rd | output | 1 | fetch from memory |
| rsp_valid | output | 1 | reply pulse |
| rsp_type | output | 2 | 0 data, 1 exclusive data, 2 ack, 3 writeback ack |
| rsp_dest | output | N | reply destination mask |
| rsp_cnt | output | AW | signed invalidation-ack count |
| rsp_dirty | output | 1 | dirty flag carried with data |
| inv_valid | output | 1 | invalidation pulse |
| inv_mask | output | N | caches to invalidate |
| fwd_valid | output | 1 | forward pulse to the owner |
| fwd_dest | output | IDW | owner index |
| fwd_excl | output | 1 | forwarded request is exclusive |

## Verification
A wrong sharer vector shows up at the ports one cycle after the next exclusive read or upgrade, as a wrong `rsp_cnt` or `inv_mask`. The bench sweeps every non-empty sharer set against every requestor for both request kinds. A wrong owner or transient state shows one cycle after the next read, as a misdirected forward, a reply where a forward belongs, or a `req_ready` that does not match the expected refusal. Both completion orders of a forwarded read are covered, and so are the writeback-acceptance and drop cases.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
  typedef enum logic [2:0] {
    EV_RD, EV_RDI, EV_WR, EV_UPG, EV_WB, EV_WB_STALE, EV_BAD
  } ev_e;

  typedef enum logic [1:0] {
    RS_DATA = 2'd0, RS_DATA_EXCL = 2'd1, RS_ACK = 2'd2, RS_WBACK = 2'd3
  } rsp_kind_e;

  typedef enum logic [3:0] {
    ST_NONE, ST_FETCH_ONE, ST_FETCH_MANY, ST_FETCH_WR,
    ST_SHARED, ST_L2MOD, ST_L1OWN,
    ST_BLK_SH, ST_BLK_OWN,
    ST_FWD_WAIT2, ST_FWD_WAIT_DATA, ST_FWD_WAIT_UNB
  } line_st_e;
endpackage

// File: rtl/l2h_req_class.sv
module l2h_req_class import l2h_pkg::*; #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic [2:0]     kind,
  input  logic           present,
  input  logic [N-1:0]   sharers,
  input  logic [IDW-1:0] src,
  output ev_e            ev
);
  logic is_sharer;
  assign is_sharer = present && sharers[src];

  always_comb begin
    case (kind)
      3'd0:    ev = EV_RD;
      3'd1:    ev = EV_RDI;
      3'd2:    ev = EV_WR;
      3'd3:    ev = is_sharer ? EV_UPG : EV_WR;
      3'd4:    ev = is_sharer ? EV_WB : EV_WB_STALE;
      default: ev = EV_BAD;
    endcase
  end
endmodule

// File: rtl/l2h_ack_calc.sv
module l2h_ack_calc #(
  parameter int N   = 4,
  parameter int IDW = 2,
  parameter int AW  = 4
) (
  input  logic [N-1:0]          sharers,
  input  logic [IDW-1:0]        src,
  output logic                  member,
  output logic [N-1:0]          others,
  output logic signed [AW-1:0]  wr_cnt,
  output logic signed [AW-1:0]  upg_cnt
);
  logic [N-1:0]  src_oh;
  logic [AW-1:0] part [N+1];

  assign part[0] = '0;
  for (genvar g = 0; g < N; g++) begin : g_pop
    assign src_oh[g]  = (src == IDW'(g));
    assign part[g+1]  = part[g] + {{(AW-1){1'b0}}, sharers[g]};
  end

  assign member  = |(sharers & src_oh);
  assign others  = sharers & ~src_oh;
  assign wr_cnt  = $signed({{(AW-1){1'b0}}, member} - part[N]);
  assign upg_cnt = $signed({{(AW-1){1'b0}}, 1'b1} - part[N]);
endmodule

// File: rtl/l2_line_home.sv
module l2_line_home import l2h_pkg::*; #(
  parameter int N = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int AW  = $clog2(N + 1) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [2:0]           req_kind,
  input  logic [IDW-1:0]       req_src,
  output logic                 req_ready,
  input  logic                 mem_valid,
  input  logic                 wbd_valid,
  input  logic                 wbd_dirty,
  input  logic                 unb_valid,
  input  logic                 unb_excl,
  input  logic [IDW-1:0]       unb_src,
  output logic                 mem_rd,
  output logic                 rsp_valid,
  output logic [1:0]           rsp_type,
  output logic [N-1:0]         rsp_dest,
  output logic signed [AW-1:0] rsp_cnt,
  output logic                 rsp_dirty,
  output logic                 inv_valid,
  output logic [N-1:0]         inv_mask,
  output logic                 fwd_valid,
  output logic [IDW-1:0]       fwd_dest,
  output logic                 fwd_excl
);
  line_st_e       st_q;
  logic [N-1:0]   sharers_q, readers_q;
  logic [IDW-1:0] owner_q, writer_q;
  logic           dirty_q;

  ev_e                  ev;
  logic                 member;
  logic [N-1:0]         others;
  logic signed [AW-1:0] wr_cnt, upg_cnt;
  logic [N-1:0]         src_oh, unb_oh, wr_oh;
  logic                 ok, take, blocking;

  l2h_req_class #(.N(N), .IDW(IDW)) u_class (
    .kind(req_kind), .present(st_q != ST_NONE), .sharers(sharers_q),
    .src(req_src), .ev(ev)
  );

  l2h_ack_calc #(.N(N), .IDW(IDW), .AW(AW)) u_ack (
    .sharers(sharers_q), .src(req_src), .member(member), .others(others),
    .wr_cnt(wr_cnt), .upg_cnt(upg_cnt)
  );

  for (genvar g = 0; g < N; g++) begin : g_oh
    assign src_oh[g] = (req_src  == IDW'(g));
    assign unb_oh[g] = (unb_src  == IDW'(g));
    assign wr_oh[g]  = (writer_q == IDW'(g));
  end

  assign blocking = st_q inside {ST_BLK_SH, ST_BLK_OWN, ST_FWD_WAIT2,
                                 ST_FWD_WAIT_DATA, ST_FWD_WAIT_UNB};

  always_comb begin
    case (st_q)
      ST_NONE, ST_SHARED, ST_L2MOD, ST_L1OWN: ok = (ev != EV_BAD);
      ST_FETCH_ONE, ST_FETCH_MANY: ok = ev inside {EV_RD, EV_RDI, EV_WB, EV_WB_STALE};
      default: ok = ev inside {EV_WB, EV_WB_STALE};
    endcase
  end

  assign req_ready = ok && !unb_valid && !mem_valid && !wbd_valid;
  assign take      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_NONE;  sharers_q <= '0; readers_q <= '0;
      owner_q <= '0;    writer_q <= '0;  dirty_q <= 1'b0;
      mem_rd <= 1'b0;   rsp_valid <= 1'b0; rsp_type <= RS_DATA;
      rsp_dest <= '0;   rsp_cnt <= '0;     rsp_dirty <= 1'b0;
      inv_valid <= 1'b0; inv_mask <= '0;
      fwd_valid <= 1'b0; fwd_dest <= '0;   fwd_excl <= 1'b0;
    end else begin
      mem_rd <= 1'b0; rsp_valid <= 1'b0; inv_valid <= 1'b0; fwd_valid <= 1'b0;
      if (unb_valid) begin
        if (unb_excl && (st_q == ST_BLK_SH || st_q == ST_BLK_OWN)) begin
          sharers_q <= unb_oh; owner_q <= unb_src; st_q <= ST_L1OWN;
        end else if (!unb_excl && st_q == ST_FWD_WAIT2) begin
          sharers_q <= sharers_q | unb_oh; st_q <= ST_FWD_WAIT_DATA;
        end else if (!unb_excl && st_q == ST_FWD_WAIT_UNB) begin
          sharers_q <= sharers_q | unb_oh; st_q <= ST_SHARED;
        end
      end else if (mem_valid) begin
        if (st_q inside {ST_FETCH_ONE, ST_FETCH_MANY, ST_FETCH_WR}) begin
          dirty_q <= 1'b0; rsp_valid <= 1'b1; rsp_cnt <= '0; rsp_dirty <= 1'b0;
          case (st_q)
            ST_FETCH_ONE: begin
              rsp_type <= RS_DATA_EXCL; rsp_dest <= readers_q; st_q <= ST_BLK_OWN;
            end
            ST_FETCH_MANY: begin
              rsp_type <= RS_DATA; rsp_dest <= readers_q; st_q <= ST_SHARED;
            end
            default: begin
              rsp_type <= RS_DATA; rsp_dest <= wr_oh; st_q <= ST_BLK_OWN;
            end
          endcase
        end
      end else if (wbd_valid) begin
        if (st_q == ST_FWD_WAIT2) begin
          dirty_q <= wbd_dirty; st_q <= ST_FWD_WAIT_UNB;
        end else if (st_q == ST_FWD_WAIT_DATA) begin
          dirty_q <= wbd_dirty; st_q <= ST_SHARED;
        end
      end else if (take) begin
        case (st_q)
          ST_NONE: begin
            if (ev == EV_RD || ev == EV_RDI) begin
              readers_q <= src_oh; sharers_q <= src_oh; mem_rd <= 1'b1;
              st_q <= (ev == EV_RD) ? ST_FETCH_ONE : ST_FETCH_MANY;
            end else if (ev == EV_WR) begin
              writer_q <= req_src; sharers_q <= '0; mem_rd <= 1'b1;
              st_q <= ST_FETCH_WR;
            end
          end
          ST_FETCH_ONE, ST_FETCH_MANY: begin
            if (ev == EV_RD || ev == EV_RDI) begin
              readers_q <= readers_q | src_oh; sharers_q <= sharers_q | src_oh;
              st_q <= ST_FETCH_MANY;
            end
          end
          ST_SHARED: begin
            if (ev == EV_RD || ev == EV_RDI) begin
              rsp_valid <= 1'b1; rsp_type <= RS_DATA; rsp_dest <= src_oh;
              rsp_cnt <= '0; rsp_dirty <= dirty_q; sharers_q <= sharers_q | src_oh;
            end else if (ev == EV_WR || ev == EV_UPG) begin
              rsp_valid <= 1'b1; rsp_dest <= src_oh; rsp_dirty <= dirty_q;
              rsp_type  <= (ev == EV_UPG) ? RS_ACK : RS_DATA;
              rsp_cnt   <= (ev == EV_UPG) ? upg_cnt : wr_cnt;
              inv_valid <= |others; inv_mask <= others;
              st_q <= ST_BLK_SH;
            end
          end
          ST_L2MOD: begin
            if (ev == EV_RDI) begin
              rsp_valid <= 1'b1; rsp_type <= RS_DATA; rsp_dest <= src_oh;
              rsp_cnt <= wr_cnt; rsp_dirty <= dirty_q;
              sharers_q <= sharers_q | src_oh; st_q <= ST_SHARED;
            end else if (ev inside {EV_RD, EV_WR, EV_UPG}) begin
              rsp_valid <= 1'b1; rsp_dest <= src_oh; rsp_dirty <= dirty_q;
              rsp_type  <= (ev == EV_RD) ? RS_DATA_EXCL : RS_DATA;
              rsp_cnt   <= (ev == EV_RD) ? '0 : wr_cnt;
              st_q <= ST_BLK_OWN;
            end
          end
          ST_L1OWN: begin
            if (ev == EV_RD || ev == EV_RDI) begin
              fwd_valid <= 1'b1; fwd_dest <= owner_q; fwd_excl <= 1'b0;
              st_q <= ST_FWD_WAIT2;
            end else if (ev == EV_WR || ev == EV_UPG) begin
              fwd_valid <= 1'b1; fwd_dest <= owner_q; fwd_excl <= 1'b1;
              st_q <= ST_BLK_OWN;
            end else if (ev == EV_WB) begin
              dirty_q <= 1'b1; sharers_q <= '0;
              rsp_valid <= 1'b1; rsp_type <= RS_WBACK; rsp_dest <= src_oh;
              rsp_cnt <= '0; rsp_dirty <= 1'b0; st_q <= ST_L2MOD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  miss_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (take && st_q == ST_NONE && req_kind != 3'd4) |=> mem_rd);
  // R4
  fetch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);
  // R6
  inv_skip_req_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && rsp_valid) |-> ((inv_mask & rsp_dest) == '0));
  // R10
  excl_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (unb_valid && unb_excl && (st_q == ST_BLK_SH || st_q == ST_BLK_OWN))
      |=> (st_q == ST_L1OWN && $countones(sharers_q) == 1));
  // R11
  wback_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == RS_WBACK) |-> ($countones(rsp_dest) == 1));
  // R12
  blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (blocking && req_valid && req_ready)
      |=> (!rsp_valid && !fwd_valid && !inv_valid && !mem_rd));
endmodule

// File: tb/test_l2_line_home.sv
`timescale 1ns/1ps
module test_l2_line_home;
  localparam int N = 4;
  localparam int IDW = 2;
  localparam int AW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0; logic [2:0] req_kind = '0; logic [IDW-1:0] req_src = '0;
  logic mem_valid = 1'b0, wbd_valid = 1'b0, wbd_dirty = 1'b0;
  logic unb_valid = 1'b0, unb_excl = 1'b0; logic [IDW-1:0] unb_src = '0;
  logic req_ready, mem_rd, rsp_valid, rsp_dirty, inv_valid, fwd_valid, fwd_excl;
  logic [1:0] rsp_type; logic [N-1:0] rsp_dest, inv_mask;
  logic signed [AW-1:0] rsp_cnt; logic [IDW-1:0] fwd_dest;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  l2_line_home #(.N(N)) i_l2_line_home (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_ready(req_ready), .mem_valid(mem_valid),
    .wbd_valid(wbd_valid), .wbd_dirty(wbd_dirty), .unb_valid(unb_valid),
    .unb_excl(unb_excl), .unb_src(unb_src), .mem_rd(mem_rd),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_dest(rsp_dest),
    .rsp_cnt(rsp_cnt), .rsp_dirty(rsp_dirty), .inv_valid(inv_valid),
    .inv_mask(inv_mask), .fwd_valid(fwd_valid), .fwd_dest(fwd_dest),
    .fwd_excl(fwd_excl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic quiet(input string tag);
    chk({tag, " rsp_valid"}, int'(rsp_valid), 0);
    chk({tag, " inv_valid"}, int'(inv_valid), 0);
    chk({tag, " fwd_valid"}, int'(fwd_valid), 0);
    chk({tag, " mem_rd"},    int'(mem_rd), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 0; mem_valid = 0; wbd_valid = 0; unb_valid = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic do_req(input int k, input int s, output bit rdy);
    req_valid = 1; req_kind = 3'(k); req_src = IDW'(s);
    #1 rdy = req_ready;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic do_mem();
    mem_valid = 1; @(negedge clk); mem_valid = 0;
  endtask

  task automatic do_wbd(input bit d);
    wbd_valid = 1; wbd_dirty = d; @(negedge clk); wbd_valid = 0;
  endtask

  task automatic do_unb(input bit x, input int s);
    unb_valid = 1; unb_excl = x; unb_src = IDW'(s); @(negedge clk); unb_valid = 0;
  endtask

  function automatic int popc(input int m);
    int c = 0;
    for (int i = 0; i < N; i++) c += (m >> i) & 1;
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    bit rdy;
    do_reset();
    // R1 reset state
    quiet("R1 reset");
    for (int k = 0; k < 5; k++) begin
      req_kind = 3'(k); #1 chk("R1 ready per kind", int'(req_ready), 1);
    end
    @(negedge clk);

    // R2/R3 single-reader fetch
    do_req(0, 2, rdy); chk("R2 ready", int'(rdy), 1); chk("R2 mem_rd", int'(mem_rd), 1);
    do_req(2, 1, rdy); chk("R4 excl read during fetch refused", int'(rdy), 0); quiet("R4");
    do_mem();
    chk("R3 rsp_valid", int'(rsp_valid), 1); chk("R3 type", int'(rsp_type), 1);
    chk("R3 dest", int'(rsp_dest), 4);       chk("R3 cnt", int'(rsp_cnt), 0);
    do_req(0, 1, rdy); chk("R12 read refused while blocked", int'(rdy), 0); quiet("R12");

    // R2/R3 write fetch, R11 writeback paths, R8 L2-modified reads
    do_reset();
    do_req(2, 3, rdy); chk("R2 write fetch mem_rd", int'(mem_rd), 1);
    do_req(0, 0, rdy); chk("R4 read during write fetch refused", int'(rdy), 0);
    do_mem();
    chk("R3 write data type", int'(rsp_type), 0); chk("R3 write data dest", int'(rsp_dest), 8);
    do_unb(1, 3);
    do_req(4, 1, rdy); chk("R11 stale writeback accepted", int'(rdy), 1); quiet("R11 stale dropped");
    do_req(0, 1, rdy); chk("R11 owner unchanged fwd", int'(fwd_valid), 1);
    chk("R11 owner unchanged dest", int'(fwd_dest), 3);
    do_unb(0, 1); do_wbd(0);
    // now shared {3,1}; take line to owned by 0 then write back
    do_req(2, 0, rdy); chk("R6 cnt", int'(rsp_cnt), -2); chk("R6 inv", int'(inv_mask), 10);
    do_unb(1, 0);
    do_req(4, 0, rdy);
    chk("R11 wback valid", int'(rsp_valid), 1); chk("R11 wback type", int'(rsp_type), 3);
    chk("R11 wback dest", int'(rsp_dest), 1);
    do_req(0, 2, rdy);
    chk("R8 excl data type", int'(rsp_type), 1); chk("R8 dirty", int'(rsp_dirty), 1);
    chk("R8 cnt", int'(rsp_cnt), 0);
    do_unb(1, 2);
    do_req(4, 2, rdy); chk("R11 second wback", int'(rsp_type), 3);
    do_req(1, 1, rdy);
    chk("R8 instr data type", int'(rsp_type), 0); chk("R8 instr dirty", int'(rsp_dirty), 1);
    do_req(0, 3, rdy); chk("R5 shared read type", int'(rsp_type), 0);
    chk("R5 shared read cnt", int'(rsp_cnt), 0); chk("R5 dest", int'(rsp_dest), 8);
    // R13 priority
    req_valid = 1; req_kind = 3'd0; req_src = 2'd0; unb_valid = 1; unb_excl = 0; unb_src = 2'd0;
    #1 chk("R13 ready low with unblock", int'(req_ready), 0);
    @(negedge clk); req_valid = 0; unb_valid = 0; quiet("R13");
    mem_valid = 1; req_valid = 1; #1 chk("R13 ready low with mem data", int'(req_ready), 0);
    @(negedge clk); req_valid = 0; mem_valid = 0; quiet("R13 shared ignores mem");
    do_req(2, 0, rdy); chk("R5 sharers {1,3} cnt", int'(rsp_cnt), -2);
    chk("R6 inv mask", int'(inv_mask), 10);
    do_unb(1, 0);
    do_req(2, 1, rdy); chk("R9 excl fwd", int'(fwd_excl), 1); chk("R9 excl fwd dest", int'(fwd_dest), 0);

    // sweep sharer sets x requestor x {excl read, upgrade}
    for (int m = 1; m < 16; m++) begin
      for (int r = 0; r < N; r++) begin
        for (int v = 0; v < 2; v++) begin
          int first, pc, q, expcnt, othr;
          bit mem, d;
          do_reset();
          first = 0;
          while (((m >> first) & 1) == 0) first++;
          do_req(1, first, rdy); chk("R2 instr miss mem_rd", int'(mem_rd), 1);
          for (int i = first + 1; i < N; i++)
            if ((m >> i) & 1) begin
              do_req(0, i, rdy); chk("R4 merge accepted", int'(rdy), 1);
            end
          do_mem();
          chk("R4 multicast type", int'(rsp_type), 0); chk("R4 multicast dest", int'(rsp_dest), m);
          chk("R4 multicast dirty", int'(rsp_dirty), 0);
          pc = popc(m); mem = (m >> r) & 1; othr = m & ~(1 << r);
          do_req(v ? 3 : 2, r, rdy);
          if (v && mem) begin
            chk("R7 upgrade type", int'(rsp_type), 2);
            chk("R7 upgrade cnt", int'(rsp_cnt), 1 - pc);
          end else begin
            expcnt = -pc + int'(mem);
            chk(v ? "R7 non-sharer upgrade type" : "R6 type", int'(rsp_type), 0);
            chk(v ? "R7 non-sharer upgrade cnt" : "R6 cnt", int'(rsp_cnt), expcnt);
          end
          chk("R6 inv_valid", int'(inv_valid), int'(othr != 0));
          if (othr != 0) chk("R6 inv mask", int'(inv_mask), othr);
          chk("R6 reply dest", int'(rsp_dest), 1 << r);
          do_req(0, r, rdy); chk("R12 refused in block", int'(rdy), 0);
          do_unb(1, r);
          q = (r + 1) % N; d = m[0];
          do_req(0, q, rdy);
          chk("R10 fwd dest", int'(fwd_dest), r); chk("R9 fwd shared", int'(fwd_excl), 0);
          chk("R9 no reply", int'(rsp_valid), 0);
          if (((m + r) & 1) != 0) begin
            do_unb(0, q);
            do_req(0, q, rdy); chk("R9 waiting data refused", int'(rdy), 0);
            do_wbd(d);
          end else begin
            do_wbd(d);
            do_req(1, q, rdy); chk("R9 waiting unblock refused", int'(rdy), 0);
            do_unb(0, q);
          end
          do_req(0, r, rdy); chk("R9 shared after both", int'(rsp_type), 0);
          chk("R9 dirty from owner", int'(rsp_dirty), int'(d));
          do_req(2, q, rdy); chk("R9 sharers cnt", int'(rsp_cnt), -1);
          chk("R9 inv owner", int'(inv_mask), 1 << r);
        end
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule